// File: doc/BRIEF.md
# UART status and interrupt register bank

This block is the software-visible side of a serial port. It sits on a 32-bit, word-only register bus. It holds the control words, the baud divisor and a few timing words. It also holds the status flags, the received character and the character waiting to be sent. The actual bit-level receiver and transmitter live elsewhere. They connect through three signals: a strobe that delivers a received character (with optional parity and framing error qualifiers), a start pulse that hands a character to the transmitter, and a done strobe that comes back when the character has left the line.

Status flags are set by serial-side events and cleared by software. Software clears them by writing ones to a dedicated clear register, by reading the received character, by requesting a receive flush, or by loading a new character to send. A single level-sensitive interrupt line is formed combinationally from the stored flags and their enables. It therefore falls in the same cycle a clearing write takes effect.

Top module: `uart_regbank`

## Requirements
- R1: After reset the status word (offset 0x1C) reads 0x020000C0 (transmit-empty bit 7 and transmit-complete bit 6 set), every other register reads zero, and `irq` is low.
- R2: A character strobe on `rx_valid` has no effect unless control word 1 (offset 0x00) has both port enable bit 0 and receiver enable bit 2 set.
- R3: An accepted character is stored and sets data-ready (status bit 5) when data-ready is clear or overrun-disable (control word 3, offset 0x08, bit 12) is set. A set `rx_perr` also sets status bit 0, and a set `rx_ferr` also sets status bit 1.
- R4: An accepted character that arrives while data-ready is set and overrun-disable is clear sets overrun (status bit 3) and leaves the stored character unchanged.
- R5: Reading the receive register (offset 0x24) returns the stored character in bits 8:0 and clears data-ready. Writing 1 to bit 3 of the request register (offset 0x18) also clears data-ready.
- R6: Writing the clear register (offset 0x20) clears each status bit where the written word has a 1. The clear register, the request register and unmapped offsets read zero. Writes to the status word and to the receive register are ignored.
- R7: Writing the transmit register (offset 0x28) stores bits 8:0. When transmitter enable (control word 1 bit 3) is set, the write also clears transmit-empty and pulses `tx_start` for one cycle with the character on `tx_data`; otherwise neither happens. A `tx_done` strobe sets transmit-empty and transmit-complete.
- R8: Every write to control word 1 copies transmitter enable into status bit 21 and receiver enable into status bit 22.
- R9: `irq` is high exactly when one of these holds, using control word 1 bits 4..8 and control word 3 bit 0:
  - data-ready AND bit 5;
  - idle (status bit 4) AND bit 4;
  - transmit-complete AND bit 6;
  - transmit-empty AND bit 7;
  - parity error AND bit 8;
  - framing error AND control word 3 bit 0;
  - overrun AND (bit 5 OR control word 3 bit 0).
- R10: The control words 1 to 3 (offsets 0x00, 0x04, 0x08), guard (0x10) and timeout (0x14) read back the full written word. The divisor (0x0C) reads back its low 16 bits, and the transmit register reads back its stored 9 bits. Read data appears on `bus_rdata` in the cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after `bus_rd` |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | CHAR_W | Received character |
| rx_perr | input | 1 | Parity error qualifier for `rx_valid` |
| rx_ferr | input | 1 | Framing error qualifier for `rx_valid` |
| tx_start | output | 1 | One-cycle pulse handing a character to the transmitter |
| tx_data | output | CHAR_W | Character to transmit |
| tx_done | input | 1 | Transmitter finished a character |
| irq | output | 1 | Level interrupt |

## Verification
A corrupted flag shows up in two places. It appears on `irq` in the very cycle after the edge that stored it, because the line is purely combinational from the flags. It also appears in the next status read, one cycle after the read strobe. A wrong overrun decision is visible as a changed character on the following receive-register read. A missed acknowledge copy shows in bits 21 and 22 of the next status read after a control write. The bench therefore interleaves every serial-side event with a status read and an `irq` sample, so any stray flag is caught within two cycles of the event that caused it.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

    localparam int unsigned BUS_W = 32;

    // Word offsets
    localparam logic [15:0] OFS_CTL1  = 16'h0000;
    localparam logic [15:0] OFS_CTL2  = 16'h0004;
    localparam logic [15:0] OFS_CTL3  = 16'h0008;
    localparam logic [15:0] OFS_BAUD  = 16'h000C;
    localparam logic [15:0] OFS_GUARD = 16'h0010;
    localparam logic [15:0] OFS_RTO   = 16'h0014;
    localparam logic [15:0] OFS_REQ   = 16'h0018;
    localparam logic [15:0] OFS_STAT  = 16'h001C;
    localparam logic [15:0] OFS_CLR   = 16'h0020;
    localparam logic [15:0] OFS_RXD   = 16'h0024;
    localparam logic [15:0] OFS_TXD   = 16'h0028;

    // Status bit positions
    localparam int unsigned ST_PERR  = 0;
    localparam int unsigned ST_FERR  = 1;
    localparam int unsigned ST_OVR   = 3;
    localparam int unsigned ST_IDLE  = 4;
    localparam int unsigned ST_RDY   = 5;
    localparam int unsigned ST_TDONE = 6;
    localparam int unsigned ST_TEMP  = 7;
    localparam int unsigned ST_TXACK = 21;
    localparam int unsigned ST_RXACK = 22;
    localparam logic [BUS_W-1:0] STAT_RESET = 32'h0200_00C0;

    // Control word 1 bit positions
    localparam int unsigned C1_PORT_EN = 0;
    localparam int unsigned C1_RX_EN   = 2;
    localparam int unsigned C1_TX_EN   = 3;
    localparam int unsigned C1_IE_IDLE = 4;
    localparam int unsigned C1_IE_RDY  = 5;
    localparam int unsigned C1_IE_TDN  = 6;
    localparam int unsigned C1_IE_TEMP = 7;
    localparam int unsigned C1_IE_PERR = 8;
    // Control word 3 bit positions
    localparam int unsigned C3_IE_ERR  = 0;
    localparam int unsigned C3_OVR_OFF = 12;
    // Request word
    localparam int unsigned RQ_RX_FLUSH = 3;

    localparam int unsigned NUM_PLAIN = 5;

    typedef struct packed {
        logic txd;
        logic rxd;
        logic clr;
        logic stat;
        logic req;
        logic rto;
        logic guard;
        logic baud;
        logic ctl3;
        logic ctl2;
        logic ctl1;
    } reg_hit_t;

    typedef struct packed {
        logic port_en;
        logic rx_en;
        logic tx_en;
        logic ovr_off;
        logic ie_idle;
        logic ie_rdy;
        logic ie_tdn;
        logic ie_temp;
        logic ie_perr;
        logic ie_err;
    } ctl_view_t;

    typedef struct packed {
        logic             clr_wr;
        logic [BUS_W-1:0] clr_mask;
        logic             rx_drain;
        logic             tx_load;
        logic             ctl1_wr;
        logic             tx_ack_nxt;
        logic             rx_ack_nxt;
        logic             rx_stb;
        logic             rx_perr;
        logic             rx_ferr;
        logic             tx_done;
    } stat_ev_t;

    function automatic reg_hit_t decode_ofs(input logic [15:0] ofs);
        reg_hit_t h;
        h.ctl1  = (ofs == OFS_CTL1);
        h.ctl2  = (ofs == OFS_CTL2);
        h.ctl3  = (ofs == OFS_CTL3);
        h.baud  = (ofs == OFS_BAUD);
        h.guard = (ofs == OFS_GUARD);
        h.rto   = (ofs == OFS_RTO);
        h.req   = (ofs == OFS_REQ);
        h.stat  = (ofs == OFS_STAT);
        h.clr   = (ofs == OFS_CLR);
        h.rxd   = (ofs == OFS_RXD);
        h.txd   = (ofs == OFS_TXD);
        return h;
    endfunction

    function automatic logic irq_calc(input logic [BUS_W-1:0] st, input ctl_view_t c);
        return (st[ST_RDY]   & c.ie_rdy)  |
               (st[ST_IDLE]  & c.ie_idle) |
               (st[ST_TDONE] & c.ie_tdn)  |
               (st[ST_TEMP]  & c.ie_temp) |
               (st[ST_PERR]  & c.ie_perr) |
               (st[ST_FERR]  & c.ie_err)  |
               (st[ST_OVR]   & (c.ie_rdy | c.ie_err));
    endfunction

endpackage

// File: rtl/uart_rb_ctrl.sv
module uart_rb_ctrl
    import uart_rb_pkg::*;
#(
    parameter int unsigned BAUD_W = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  reg_hit_t                        hit,
    input  logic [BUS_W-1:0]                wdata,
    output logic [NUM_PLAIN-1:0][BUS_W-1:0] plain_q,
    output logic [BAUD_W-1:0]               baud_q,
    output ctl_view_t                       view
);
    // Plain words in order: ctl1, ctl2, ctl3, guard, timeout
    logic [NUM_PLAIN-1:0] wsel;
    assign wsel = {hit.rto, hit.guard, hit.ctl3, hit.ctl2, hit.ctl1};

    for (genvar i = 0; i < NUM_PLAIN; i++) begin : g_plain
        always_ff @(posedge clk) begin
            if (rst) begin
                plain_q[i] <= '0;
            end else if (wr_en && wsel[i]) begin
                plain_q[i] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            baud_q <= '0;
        end else if (wr_en && hit.baud) begin
            baud_q <= wdata[BAUD_W-1:0];
        end
    end

    always_comb begin
        view.port_en = plain_q[0][C1_PORT_EN];
        view.rx_en   = plain_q[0][C1_RX_EN];
        view.tx_en   = plain_q[0][C1_TX_EN];
        view.ie_idle = plain_q[0][C1_IE_IDLE];
        view.ie_rdy  = plain_q[0][C1_IE_RDY];
        view.ie_tdn  = plain_q[0][C1_IE_TDN];
        view.ie_temp = plain_q[0][C1_IE_TEMP];
        view.ie_perr = plain_q[0][C1_IE_PERR];
        view.ie_err  = plain_q[2][C3_IE_ERR];
        view.ovr_off = plain_q[2][C3_OVR_OFF];
    end
endmodule

// File: rtl/uart_rb_status.sv
module uart_rb_status
    import uart_rb_pkg::*;
#(
    parameter int unsigned CHAR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  stat_ev_t          ev,
    input  logic [CHAR_W-1:0] rx_char,
    input  ctl_view_t         view,
    output logic [BUS_W-1:0]  status_q,
    output logic [CHAR_W-1:0] rxd_q
);
    logic [BUS_W-1:0] status_d;
    logic             rx_take;
    logic             rx_block;

    assign rx_take  = ev.rx_stb && view.port_en && view.rx_en;
    assign rx_block = rx_take && status_q[ST_RDY] && !view.ovr_off;

    // Software clears first, hardware sets last so no event is lost
    always_comb begin
        status_d = status_q;
        if (ev.clr_wr) begin
            status_d = status_d & ~ev.clr_mask;
        end
        if (ev.rx_drain) begin
            status_d[ST_RDY] = 1'b0;
        end
        if (ev.tx_load) begin
            status_d[ST_TEMP] = 1'b0;
        end
        if (ev.ctl1_wr) begin
            status_d[ST_TXACK] = ev.tx_ack_nxt;
            status_d[ST_RXACK] = ev.rx_ack_nxt;
        end
        if (rx_take) begin
            if (rx_block) begin
                status_d[ST_OVR] = 1'b1;
            end else begin
                status_d[ST_RDY] = 1'b1;
            end
            if (ev.rx_perr) begin
                status_d[ST_PERR] = 1'b1;
            end
            if (ev.rx_ferr) begin
                status_d[ST_FERR] = 1'b1;
            end
        end
        if (ev.tx_done) begin
            status_d[ST_TEMP]  = 1'b1;
            status_d[ST_TDONE] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= STAT_RESET;
            rxd_q    <= '0;
        end else begin
            status_q <= status_d;
            if (rx_take && !rx_block) begin
                rxd_q <= rx_char;
            end
        end
    end
endmodule

// File: rtl/uart_rb_irq.sv
module uart_rb_irq
    import uart_rb_pkg::*;
(
    input  logic [BUS_W-1:0] status_q,
    input  ctl_view_t        view,
    output logic             irq
);
    assign irq = irq_calc(status_q, view);
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_rb_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CHAR_W = 9,
    parameter int unsigned BAUD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    output logic              tx_start,
    output logic [CHAR_W-1:0] tx_data,
    input  logic              tx_done,
    output logic              irq
);
    localparam int unsigned CHAR_PAD = BUS_W - CHAR_W;
    localparam int unsigned BAUD_PAD = BUS_W - BAUD_W;

    logic [15:0]                     ofs;
    reg_hit_t                        hit;
    logic [NUM_PLAIN-1:0][BUS_W-1:0] plain_q;
    logic [BAUD_W-1:0]               baud_q;
    ctl_view_t                       view;
    stat_ev_t                        ev;
    logic [BUS_W-1:0]                status_q;
    logic [CHAR_W-1:0]               rxd_q;
    logic [CHAR_W-1:0]               txd_q;
    logic                            tx_go;

    assign ofs = 16'(bus_addr);
    assign hit = decode_ofs(ofs);

    uart_rb_ctrl #(.BAUD_W(BAUD_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr),
        .hit     (hit),
        .wdata   (bus_wdata),
        .plain_q (plain_q),
        .baud_q  (baud_q),
        .view    (view)
    );

    assign tx_go = bus_wr && hit.txd && view.tx_en;

    always_comb begin
        ev.clr_wr     = bus_wr && hit.clr;
        ev.clr_mask   = bus_wdata;
        ev.rx_drain   = (bus_rd && hit.rxd) ||
                        (bus_wr && hit.req && bus_wdata[RQ_RX_FLUSH]);
        ev.tx_load    = tx_go;
        ev.ctl1_wr    = bus_wr && hit.ctl1;
        ev.tx_ack_nxt = bus_wdata[C1_TX_EN];
        ev.rx_ack_nxt = bus_wdata[C1_RX_EN];
        ev.rx_stb     = rx_valid;
        ev.rx_perr    = rx_perr;
        ev.rx_ferr    = rx_ferr;
        ev.tx_done    = tx_done;
    end

    uart_rb_status #(.CHAR_W(CHAR_W)) u_status (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .rx_char  (rx_data),
        .view     (view),
        .status_q (status_q),
        .rxd_q    (rxd_q)
    );

    uart_rb_irq u_irq (
        .status_q (status_q),
        .view     (view),
        .irq      (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            txd_q    <= '0;
            tx_start <= 1'b0;
        end else begin
            tx_start <= tx_go;
            if (bus_wr && hit.txd) begin
                txd_q <= bus_wdata[CHAR_W-1:0];
            end
        end
    end
    assign tx_data = txd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            unique case (1'b1)
                hit.ctl1:  bus_rdata <= plain_q[0];
                hit.ctl2:  bus_rdata <= plain_q[1];
                hit.ctl3:  bus_rdata <= plain_q[2];
                hit.guard: bus_rdata <= plain_q[3];
                hit.rto:   bus_rdata <= plain_q[4];
                hit.baud:  bus_rdata <= {{BAUD_PAD{1'b0}}, baud_q};
                hit.stat:  bus_rdata <= status_q;
                hit.rxd:   bus_rdata <= {{CHAR_PAD{1'b0}}, rxd_q};
                hit.txd:   bus_rdata <= {{CHAR_PAD{1'b0}}, txd_q};
                default:   bus_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/uart_rb_checker.sv
module uart_rb_checker #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CHAR_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              rx_valid,
    input logic [CHAR_W-1:0] rx_data,
    input logic              tx_start,
    input logic              tx_done,
    input logic              irq,
    input logic [31:0]       status_q,
    input logic [CHAR_W-1:0] rxd_q,
    input logic [31:0]       ctl1_q,
    input logic [31:0]       ctl3_q
);
    logic rx_on;
    assign rx_on = ctl1_q[0] && ctl1_q[2];

    p_rx_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_on) |=> ($stable(rxd_q) && !$rose(status_q[5])));

    p_rx_store_r3: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_on && !status_q[5]) |=> (status_q[5] && rxd_q == $past(rx_data)));

    p_overrun_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_on && status_q[5] && !ctl3_q[12]) |=> (status_q[3] && $stable(rxd_q)));

    p_drain_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'('h24) && !rx_valid) |=> !status_q[5]);

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'('h20) && !rx_valid && !tx_done)
        |=> ((status_q & $past(bus_wdata)) == 32'h0));

    p_tx_gate_r7: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> $past(ctl1_q[3]));

    p_ack_copy_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'('h00))
        |=> (status_q[21] == $past(bus_wdata[3]) && status_q[22] == $past(bus_wdata[2])));

    p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((|ctl1_q[8:4]) || ctl3_q[0]));
endmodule

bind uart_regbank uart_rb_checker #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .tx_start  (tx_start),
    .tx_done   (tx_done),
    .irq       (irq),
    .status_q  (status_q),
    .rxd_q     (rxd_q),
    .ctl1_q    (plain_q[0]),
    .ctl3_q    (plain_q[2])
);

// File: tb/uart_regbank_bench.sv
module uart_regbank_bench;
    localparam int ADDR_W = 8;
    localparam int CHAR_W = 9;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_rd = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              rx_valid = 1'b0;
    logic [CHAR_W-1:0] rx_data = '0;
    logic              rx_perr = 1'b0;
    logic              rx_ferr = 1'b0;
    logic              tx_start;
    logic [CHAR_W-1:0] tx_data;
    logic              tx_done = 1'b0;
    logic              irq;

    int  n_run  = 0;
    int  n_fail = 0;
    int  cyc    = 0;
    bit  done   = 0;
    logic rd_seen = 1'b0;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    uart_regbank #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W)) u_uart_regbank (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .tx_start(tx_start), .tx_data(tx_data),
        .tx_done(tx_done), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: compares read data one cycle after each read strobe
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                chk("monitor-underflow", 32'h1, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, bus_rdata, e.val);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        e.val = exp; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rx(input logic [8:0] c, input logic pe, input logic fe);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = c; rx_perr = pe; rx_ferr = fe;
        @(negedge clk);
        rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
    endtask

    task automatic txd_done();
        @(negedge clk);
        tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000 && !done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got 0x%08h expected 0x%08h", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        rd(8'h1C, 32'h0200_00C0, "R1 status reset");
        rd(8'h00, 32'h0, "R1 ctl1 reset");
        rd(8'h0C, 32'h0, "R1 divisor reset");
        rd(8'h24, 32'h0, "R1 rx data reset");

        // R10 readback
        wr(8'h0C, 32'h1234_5678);
        rd(8'h0C, 32'h0000_5678, "R10 divisor low 16 bits");
        wr(8'h04, 32'hDEAD_BEEF);
        rd(8'h04, 32'hDEAD_BEEF, "R10 ctl2 readback");
        wr(8'h14, 32'h00AB_CDEF);
        rd(8'h14, 32'h00AB_CDEF, "R10 timeout readback");

        // R2 receiver disabled
        rx(9'h1A5, 1'b0, 1'b0);
        rd(8'h1C, 32'h0200_00C0, "R2 no data-ready while disabled");
        rd(8'h24, 32'h0, "R2 character not stored");
        wr(8'h00, 32'h0000_0004);
        rx(9'h1A5, 1'b0, 1'b0);
        rd(8'h24, 32'h0, "R2 receiver without port enable");

        // R8 acks
        wr(8'h00, 32'h0000_000D);
        rd(8'h1C, 32'h0260_00C0, "R8 ack bits set");

        // R3 / R4 / R5
        rx(9'h1A5, 1'b0, 1'b0);
        rd(8'h1C, 32'h0260_00E0, "R3 data-ready set");
        rx(9'h033, 1'b0, 1'b0);
        rd(8'h1C, 32'h0260_00E8, "R4 overrun set");
        rd(8'h24, 32'h0000_01A5, "R4 first character kept");
        rd(8'h1C, 32'h0260_00C8, "R5 read clears data-ready");

        // R6 clear register and ignored writes
        wr(8'h20, 32'h0000_0008);
        rd(8'h1C, 32'h0260_00C0, "R6 overrun cleared");
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h1C, 32'h0260_00C0, "R6 status write ignored");
        rd(8'h20, 32'h0, "R6 clear reads zero");
        wr(8'h18, 32'h0000_0010);
        rd(8'h18, 32'h0, "R6 request reads zero");
        rd(8'h3C, 32'h0, "R6 unmapped reads zero");

        // R3 overrun disabled, R5 flush
        wr(8'h08, 32'h0000_1000);
        rx(9'h011, 1'b0, 1'b0);
        rx(9'h022, 1'b0, 1'b0);
        rd(8'h1C, 32'h0260_00E0, "R3 no overrun when disabled");
        wr(8'h18, 32'h0000_0008);
        rd(8'h1C, 32'h0260_00C0, "R5 flush clears data-ready");
        rd(8'h24, 32'h0000_0022, "R3 newest character stored");
        wr(8'h24, 32'h0000_00FF);
        rd(8'h24, 32'h0000_0022, "R6 rx data write ignored");

        // R3 error qualifiers
        rx(9'h055, 1'b1, 1'b1);
        rd(8'h1C, 32'h0260_00E3, "R3 parity and framing flags");
        wr(8'h20, 32'h0000_0023);
        rd(8'h1C, 32'h0260_00C0, "R6 multi-bit clear");

        // R7 transmit
        wr(8'h28, 32'h0000_00AB);
        chk("R7 tx_start pulse", {31'b0, tx_start}, 32'h1);
        chk("R7 tx_data", {23'b0, tx_data}, 32'h0AB);
        @(negedge clk);
        chk("R7 tx_start one cycle", {31'b0, tx_start}, 32'h0);
        rd(8'h1C, 32'h0260_0040, "R7 transmit-empty cleared");
        wr(8'h20, 32'h0000_0040);
        rd(8'h1C, 32'h0260_0000, "R6 transmit-complete cleared");
        txd_done();
        rd(8'h1C, 32'h0260_00C0, "R7 done sets both flags");
        rd(8'h28, 32'h0000_00AB, "R10 tx register readback");

        wr(8'h00, 32'h0000_0005);
        rd(8'h1C, 32'h0240_00C0, "R8 tx ack follows enable");
        wr(8'h28, 32'h0000_0011);
        chk("R7 no start without enable", {31'b0, tx_start}, 32'h0);
        rd(8'h1C, 32'h0240_00C0, "R7 empty kept without enable");
        rd(8'h28, 32'h0000_0011, "R7 character still stored");

        // R9 interrupt
        wr(8'h00, 32'h0000_0085);
        chk("R9 transmit-empty irq", {31'b0, irq}, 32'h1);
        wr(8'h00, 32'h0000_0005);
        chk("R9 irq off without enable", {31'b0, irq}, 32'h0);
        wr(8'h00, 32'h0000_0045);
        chk("R9 transmit-complete irq", {31'b0, irq}, 32'h1);
        wr(8'h20, 32'h0000_0040);
        chk("R9 irq drops with clear", {31'b0, irq}, 32'h0);
        wr(8'h00, 32'h0000_0005);
        wr(8'h08, 32'h0);
        rx(9'h001, 1'b0, 1'b0);
        rx(9'h002, 1'b0, 1'b0);
        chk("R9 overrun without enable", {31'b0, irq}, 32'h0);
        wr(8'h08, 32'h0000_0001);
        chk("R9 overrun via error enable", {31'b0, irq}, 32'h1);
        wr(8'h08, 32'h0);
        wr(8'h00, 32'h0000_0025);
        chk("R9 overrun via data-ready enable", {31'b0, irq}, 32'h1);
        wr(8'h20, 32'h0000_0028);
        chk("R9 irq after clearing", {31'b0, irq}, 32'h0);
        wr(8'h00, 32'h0000_0005);
        rx(9'h003, 1'b1, 1'b0);
        chk("R9 parity without enable", {31'b0, irq}, 32'h0);
        wr(8'h00, 32'h0000_0105);
        chk("R9 parity irq", {31'b0, irq}, 32'h1);
        wr(8'h20, 32'h0000_0021);
        chk("R9 parity cleared", {31'b0, irq}, 32'h0);
        rx(9'h004, 1'b0, 1'b1);
        wr(8'h08, 32'h0000_0001);
        chk("R9 framing irq", {31'b0, irq}, 32'h1);
        wr(8'h20, 32'h0000_0022);
        chk("R9 framing cleared", {31'b0, irq}, 32'h0);
        rd(8'h1C, 32'h0240_0080, "R9 final status");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) chk("monitor-drain", exp_q.size(), 0);
        done = 1;
        summary();
        $finish;
    end
endmodule